// File: doc/BRIEF.md
# Power-Management I/O Window Decoder

This block holds the configuration registers that place two I/O windows of a power-management function anywhere in a 16-bit I/O space. One is a 128-byte window for the power-management register block. The other is a 16-byte window for an SMBus controller. Software programs each window through a dword-addressed configuration port that has per-byte write enables. Every I/O address presented to the block is then compared with both windows. The block raises at most one hit and gives the offset of the address inside the window that matched.

Each base register stores only the address bits above its window size. Bit 0 of a base register always reads as 1, which marks it as an I/O window. All other bits read as 0. The power-management window decodes only while bit 7 of its control byte is set. The SMBus window decodes only while bit 0 of its control byte is set, and that control byte holds just four bits. A small read-only identity stub answers at dword 0 and dword 2. Reads of every other unmapped dword return zero.

Top module: `pmio_window_dec`

## Requirements
- R1: After reset, dword 0x12 (byte 0x48, the power-management base) and dword 0x24 (byte 0x90, the SMBus base) both read 0x00000001. Dword 0x10 and dword 0x34 read 0, and neither hit output is asserted.
- R2: The power-management base keeps address bits 15:7 only. On a read, bit 0 is 1 and bits 6:1 and 31:16 are 0.
- R3: The SMBus base keeps address bits 15:4 only. On a read, bit 0 is 1 and bits 3:1 and 31:16 are 0.
- R4: The power-management window decodes only when bit 7 of byte 0x41 (lane 1 of dword 0x10) is set, `io_addr[15:7]` equals the base, and `io_wide` is 0. In that case `pm_off = io_addr[6:0]`.
- R5: The SMBus window decodes only when bit 0 of byte 0xD2 (lane 2 of dword 0x34) is set and `io_addr[15:4]` equals the SMBus base. In that case `smb_off = io_addr[3:0]`.
- R6: A write to byte 0xD2 keeps its low four bits. Bits 23:20 of dword 0x34 always read as 0.
- R7: A write changes only the bytes whose `cfg_be` bit is set. A write with all four lanes enabled updates a whole register in one clock, and the new decode is visible right after that edge.
- R8: When both windows match one address, only `pm_hit` is asserted. `pm_hit` and `smb_hit` are never high together.
- R9: Dword 0 reads `{DEVICE_ID, VENDOR_ID}` and dword 2 reads `{CLASS_CODE, REV_ID}`. Writes to these dwords are ignored, and unmapped dwords read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dw | input | 6 | Configuration dword index (byte offset / 4) |
| cfg_be | input | 4 | Per-byte write enables |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_dw` (combinational) |
| io_addr | input | 16 | I/O address to decode |
| io_wide | input | 1 | 1 when the I/O access is wider than a byte |
| pm_hit | output | 1 | Address falls in the power-management window |
| pm_off | output | 7 | Offset inside the power-management window |
| smb_hit | output | 1 | Address falls in the SMBus window |
| smb_off | output | 4 | Offset inside the SMBus window |

## Verification
Two things can decide the result in the same cycle: the overlap priority and the byte-width gate on the power-management window. To provoke this, the SMBus base is moved inside the enabled power-management window. The same address is then presented first as a byte access and then as a wide access. For the byte access, only `pm_hit` may rise. For the wide access, the power-management window drops out and the SMBus window must take the address with the correct offset. A later partial-lane write moves the power-management base away, and the bench checks that the SMBus window keeps decoding that address.

// File: rtl/pmio_window_dec.sv
module pmio_window_dec #(
  parameter int          IO_AW       = 16,
  parameter int          PM_LOG2     = 7,
  parameter int          SMB_LOG2    = 4,
  parameter logic [15:0] VENDOR_ID   = 16'hA5C0,
  parameter logic [15:0] DEVICE_ID   = 16'h0571,
  parameter logic [7:0]  REV_ID      = 8'h40,
  parameter logic [23:0] CLASS_CODE  = 24'h068000,
  parameter logic [5:0]  PM_EN_DW    = 6'h10,
  parameter logic [5:0]  PM_BASE_DW  = 6'h12,
  parameter logic [5:0]  SMB_BASE_DW = 6'h24,
  parameter logic [5:0]  SMB_EN_DW   = 6'h34
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [5:0]          cfg_dw,
  input  logic [3:0]          cfg_be,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  input  logic [IO_AW-1:0]    io_addr,
  input  logic                io_wide,
  output logic                pm_hit,
  output logic [PM_LOG2-1:0]  pm_off,
  output logic                smb_hit,
  output logic [SMB_LOG2-1:0] smb_off
);
  localparam int PM_BW  = IO_AW - PM_LOG2;
  localparam int SMB_BW = IO_AW - SMB_LOG2;

  logic [PM_BW-1:0]  pm_base;
  logic [SMB_BW-1:0] smb_base;
  logic [7:0]        pm_ctl;
  logic [3:0]        smb_ctl;
  logic [31:0]       wr_merged;
  logic              pm_match, smb_match;
  logic              unused_bits;

  always_comb begin
    cfg_rdata = '0;
    case (cfg_dw)
      6'h00:       cfg_rdata = {DEVICE_ID, VENDOR_ID};
      6'h02:       cfg_rdata = {CLASS_CODE, REV_ID};
      PM_EN_DW:    cfg_rdata[15:8] = pm_ctl;
      PM_BASE_DW:  begin cfg_rdata[IO_AW-1:PM_LOG2] = pm_base; cfg_rdata[0] = 1'b1; end
      SMB_BASE_DW: begin cfg_rdata[IO_AW-1:SMB_LOG2] = smb_base; cfg_rdata[0] = 1'b1; end
      SMB_EN_DW:   cfg_rdata[19:16] = smb_ctl;
      default:     cfg_rdata = '0;
    endcase
  end

  for (genvar b = 0; b < 4; b++) begin : g_lane
    assign wr_merged[8*b +: 8] = cfg_be[b] ? cfg_wdata[8*b +: 8] : cfg_rdata[8*b +: 8];
  end
  assign unused_bits = ^wr_merged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pm_base  <= '0;
      smb_base <= '0;
      pm_ctl   <= '0;
      smb_ctl  <= '0;
    end else if (cfg_we) begin
      if (cfg_dw == PM_BASE_DW)  pm_base  <= wr_merged[IO_AW-1:PM_LOG2];
      if (cfg_dw == SMB_BASE_DW) smb_base <= wr_merged[IO_AW-1:SMB_LOG2];
      if (cfg_dw == PM_EN_DW)    pm_ctl   <= wr_merged[15:8];
      if (cfg_dw == SMB_EN_DW)   smb_ctl  <= wr_merged[19:16];
    end
  end

  assign pm_match  = pm_ctl[7] && !io_wide && (io_addr[IO_AW-1:PM_LOG2] == pm_base);
  assign smb_match = smb_ctl[0] && (io_addr[IO_AW-1:SMB_LOG2] == smb_base);
  assign pm_hit    = pm_match;
  assign smb_hit   = smb_match && !pm_match;
  assign pm_off    = io_addr[PM_LOG2-1:0];
  assign smb_off   = io_addr[SMB_LOG2-1:0];
endmodule

// File: rtl/pmio_window_dec_chk.sv
module pmio_window_dec_chk #(
  parameter int          IO_AW       = 16,
  parameter int          PM_LOG2     = 7,
  parameter int          SMB_LOG2    = 4,
  parameter logic [15:0] VENDOR_ID   = 16'hA5C0,
  parameter logic [15:0] DEVICE_ID   = 16'h0571,
  parameter logic [5:0]  PM_BASE_DW  = 6'h12,
  parameter logic [5:0]  SMB_BASE_DW = 6'h24,
  parameter logic [5:0]  SMB_EN_DW   = 6'h34
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_we,
  input logic [5:0]          cfg_dw,
  input logic [3:0]          cfg_be,
  input logic [31:0]         cfg_wdata,
  input logic [31:0]         cfg_rdata,
  input logic [IO_AW-1:0]    io_addr,
  input logic                io_wide,
  input logic                pm_hit,
  input logic [PM_LOG2-1:0]  pm_off,
  input logic                smb_hit,
  input logic [SMB_LOG2-1:0] smb_off
);
  p_one_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pm_hit && smb_hit));
  p_pm_byte_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    io_wide |-> !pm_hit);
  p_pm_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pm_hit |-> pm_off == io_addr[PM_LOG2-1:0]);
  p_smb_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    smb_hit |-> smb_off == io_addr[SMB_LOG2-1:0]);
  p_pm_base_fmt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dw == PM_BASE_DW) |-> (cfg_rdata[0] && cfg_rdata[PM_LOG2-1:1] == '0 && cfg_rdata[31:IO_AW] == '0));
  p_smb_base_fmt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dw == SMB_BASE_DW) |-> (cfg_rdata[0] && cfg_rdata[SMB_LOG2-1:1] == '0 && cfg_rdata[31:IO_AW] == '0));
  p_smb_ctl_nibble_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dw == SMB_EN_DW) |-> cfg_rdata[23:20] == 4'h0);
  p_ident_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dw == 6'h00) |-> cfg_rdata == {DEVICE_ID, VENDOR_ID});
  p_partial_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_dw == PM_BASE_DW && cfg_be == 4'b0001) |=>
      ($past(cfg_dw) != cfg_dw) || cfg_rdata[15:8] == $past(cfg_rdata[15:8]));
endmodule

bind pmio_window_dec pmio_window_dec_chk #(
  .IO_AW(IO_AW), .PM_LOG2(PM_LOG2), .SMB_LOG2(SMB_LOG2),
  .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID),
  .PM_BASE_DW(PM_BASE_DW), .SMB_BASE_DW(SMB_BASE_DW), .SMB_EN_DW(SMB_EN_DW)
) u_chk (.*);

// File: tb/pmio_window_dec_tb.sv
module pmio_window_dec_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_dw = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [15:0] io_addr = '0;
  logic        io_wide = 1'b0;
  logic        pm_hit, smb_hit;
  logic [6:0]  pm_off;
  logic [3:0]  smb_off;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pmio_window_dec u_dut (.*);

  // {we, dw, be, wdata, io_addr, io_wide, exp_pm, exp_smb, exp_off}
  localparam int NV = 14;
  localparam logic [68:0] VEC [NV] = '{
    {1'b1, 6'h10, 4'b0010, 32'h0000_8000, 16'h0005, 1'b0, 1'b1, 1'b0, 7'h05},
    {1'b1, 6'h12, 4'b1111, 32'hFFFF_1234, 16'h1237, 1'b0, 1'b1, 1'b0, 7'h37},
    {1'b0, 6'h00, 4'b0000, 32'h0,         16'h1280, 1'b0, 1'b0, 1'b0, 7'h00},
    {1'b0, 6'h00, 4'b0000, 32'h0,         16'h127F, 1'b0, 1'b1, 1'b0, 7'h7F},
    {1'b0, 6'h00, 4'b0000, 32'h0,         16'h1210, 1'b1, 1'b0, 1'b0, 7'h00},
    {1'b1, 6'h24, 4'b1111, 32'h0000_ABCD, 16'hABC3, 1'b0, 1'b0, 1'b0, 7'h00},
    {1'b1, 6'h34, 4'b0100, 32'h00FF_0000, 16'hABC3, 1'b0, 1'b0, 1'b1, 7'h03},
    {1'b0, 6'h00, 4'b0000, 32'h0,         16'hABCF, 1'b0, 1'b0, 1'b1, 7'h0F},
    {1'b0, 6'h00, 4'b0000, 32'h0,         16'hABD0, 1'b0, 1'b0, 1'b0, 7'h00},
    {1'b1, 6'h24, 4'b0011, 32'h0000_1205, 16'h1204, 1'b0, 1'b1, 1'b0, 7'h04},
    {1'b0, 6'h00, 4'b0000, 32'h0,         16'h1204, 1'b1, 1'b0, 1'b1, 7'h04},
    {1'b1, 6'h12, 4'b0010, 32'h0000_3400, 16'h1204, 1'b0, 1'b0, 1'b1, 7'h04},
    {1'b1, 6'h34, 4'b0100, 32'h00FE_0000, 16'h1204, 1'b0, 1'b0, 1'b0, 7'h00},
    {1'b1, 6'h10, 4'b0010, 32'h0000_0000, 16'h3401, 1'b0, 1'b0, 1'b0, 7'h00}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(logic [5:0] dw, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_dw = dw; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(string req, logic [5:0] dw, logic [31:0] exp);
    @(negedge clk);
    cfg_dw = dw;
    #1 check(req, cfg_rdata, exp);
  endtask

  task automatic probe(string req, logic [15:0] a, logic w, logic ep, logic es);
    @(negedge clk);
    io_addr = a; io_wide = w;
    #1;
    check({req, " pm_hit"}, 32'(pm_hit), 32'(ep));
    check({req, " smb_hit"}, 32'(smb_hit), 32'(es));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    cfg_read("R1 pm base", 6'h12, 32'h0000_0001);
    cfg_read("R1 smb base", 6'h24, 32'h0000_0001);
    cfg_read("R1 pm ctl", 6'h10, 32'h0);
    cfg_read("R1 smb ctl", 6'h34, 32'h0);
    probe("R1", 16'h0000, 1'b0, 1'b0, 1'b0);

    // table: R4 R5 R7 R8 decode
    for (int i = 0; i < NV; i++) begin
      logic [68:0] v;
      v = VEC[i];
      @(negedge clk);
      cfg_we = v[68]; cfg_dw = v[67:62]; cfg_be = v[61:58]; cfg_wdata = v[57:26];
      @(negedge clk);
      cfg_we = 1'b0; io_addr = v[25:10]; io_wide = v[9];
      #1;
      check($sformatf("R4 R5 R7 R8 vec%0d pm_hit", i), 32'(pm_hit), 32'(v[8]));
      check($sformatf("R4 R5 R7 R8 vec%0d smb_hit", i), 32'(smb_hit), 32'(v[7]));
      if (v[8]) check($sformatf("R4 vec%0d pm_off", i), 32'(pm_off), 32'(v[6:0]));
      if (v[7]) check($sformatf("R5 vec%0d smb_off", i), 32'(smb_off), 32'(v[6:0]));
    end

    // R2 R3 R7 readback after table
    cfg_read("R2 R7 pm base", 6'h12, 32'h0000_3401);
    cfg_read("R3 smb base", 6'h24, 32'h0000_1201);
    cfg_read("R6 smb ctl", 6'h34, 32'h000E_0000);
    cfg_read("R4 pm ctl", 6'h10, 32'h0);
    cfg_write(6'h24, 4'b1111, 32'hFFFF_FFFF);
    cfg_read("R3 smb mask", 6'h24, 32'h0000_FFF1);
    cfg_write(6'h12, 4'b1111, 32'hFFFF_FFFF);
    cfg_read("R2 pm mask", 6'h12, 32'h0000_FF81);

    // R6 upper nibble dropped
    cfg_write(6'h34, 4'b0100, 32'hA5F1_0000);
    cfg_read("R6 nibble", 6'h34, 32'h0001_0000);
    cfg_write(6'h34, 4'b1011, 32'hFFFF_FFFF);
    cfg_read("R7 lane masked", 6'h34, 32'h0001_0000);

    // R9 identity
    cfg_read("R9 id", 6'h00, 32'h0571_A5C0);
    cfg_write(6'h00, 4'b1111, 32'h1234_5678);
    cfg_read("R9 id after write", 6'h00, 32'h0571_A5C0);
    cfg_read("R9 class", 6'h02, 32'h0680_0040);
    cfg_write(6'h20, 4'b1111, 32'hFFFF_FFFF);
    cfg_read("R9 unmapped", 6'h20, 32'h0);

    // R5 smb at top of range, then R1 reset mid-run
    probe("R5 smb top", 16'hFFF7, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R1 reset hit", 32'(smb_hit), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    cfg_read("R1 reset pm base", 6'h12, 32'h0000_0001);
    cfg_read("R1 reset smb ctl", 6'h34, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule